// File: doc/BRIEF.md
# Phased Instruction Control Sequencer

This block is the control unit of a small 8-bit processor with a 16-bit address space. It keeps the instruction register and a phase counter. From the opcode and the current phase it drives one-hot control strobes into a datapath that lives outside the block. The strobes cover four groups: sources and loads on the address bus, register sources and loads on the data bus, memory read and write, and ALU function with condition-code load. The outside datapath holds the PC, the incrementer latch, XY, M, J, the eight byte registers, the ALU and the memory.

Each instruction starts with the same four-phase fetch. The address bus carries the PC while memory is read. The opcode is captured and the incrementer latch loads. Then the incremented value is written back to the PC. Single-byte instructions finish in 8 phases. Jump, call and the four conditional branches take 24 phases. Each operand byte is fetched in its own 8-phase slot, using the same pattern as the opcode fetch, and the instruction executes in the last slot. Branch decisions use the zero, carry and sign flags, which arrive as plain inputs.

Top module: `instr_sequencer`

## Requirements
- R1: While reset is active, and in the cycle after it is released, `phase` is 0, `halted` is 0, and the only active strobes are `addr_sel` bit 0 and `mem_rd`. Bit positions are fixed. `addr_sel`: 0 PC, 1 incrementer, 2 M, 3 XY, 4 J. `addr_ld`: 0 PC, 1 XY, 2 incrementer. Bit i of `dreg_sel`/`dreg_ld` is register i, in the order A, B, C, D, M1, M2, X, Y.
- R2: Phases 0 to 3 of every instruction carry the fetch sequence:
  - Phase 0: PC source and `mem_rd`.
  - Phase 1: the same, plus the incrementer load. `mem_rdata` is captured as the opcode at the end of phase 1.
  - Phase 2: incrementer source.
  - Phase 3: incrementer source and PC load.
- R3: `phase` counts up by one per clock. It returns to 0 after phase 7 for every single-byte opcode, and after phase 23 for the six three-byte opcodes. Opcodes not listed here run as 8-phase no-ops with no strobes in phases 4 to 7.
- R4: Move `00dddsss` drives register sss in phases 4 and 5 and loads register ddd in phase 5.
- R5: ALU `1000rfff` drives `alu_oe` with `alu_fn`=fff in phases 4 and 5. In phase 5 it also loads A (r=0) or D (r=1) and pulses `cc_ld`. `alu_fn` is 0 outside these phases.
- R6: Load-immediate `01rddddd` places ddddd sign-extended to 8 bits on `imm_val` with `imm_oe` in phases 4 and 5, and loads A (r=0) or B (r=1) in phase 5.
- R7: Load `100100rr` uses the M source with `mem_rd` in phases 4 and 5 and loads register rr in phase 5. Store `100110rr` uses the M source and drives register rr in phases 4 and 5, with `mem_wr` in phase 5 only.
- R8: XY increment `10110000` does three things. Phase 4: XY source with incrementer load. Phase 5: incrementer source. Phase 6: incrementer source with XY load.
- R9: Wide move `1010dss0` does two things:
  - Phases 4 and 5 select source ss (00 M, 01 XY, 10 J).
  - Phase 5 loads the PC (d=1) or XY (d=0).
  
  `10101010` is therefore a return, and `10100110` is a no-op.
- R10: For three-byte opcodes, phases 8 to 11 and 16 to 19 repeat the fetch pattern of R2. The opcode capture in phase 1 is replaced by `j_ld[1]` (high byte) in phase 9 and by `j_ld[0]` (low byte) in phase 17.
- R11: A jump `11100110`, or a branch whose condition holds, drives the J source in phases 20 and 21 and loads the PC in phase 21. The branches are `11110000` on sign, `11101000` on carry, `11100100` on zero and `11100010` on not-zero.
- R12: A branch whose condition is false drives no strobe in phases 20 to 23.
- R13: Call `11100111` does two things. Phases 20 and 21 put the PC on the bus and load XY in phase 21. Phases 22 and 23 put J on the bus and load the PC in phase 23.
- R14: Halt `10101110` holds `phase` at 4 with `halted` high and every strobe low until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Data bus value during memory reads |
| flag_z | input | 1 | Zero flag from the condition-code register |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| phase | output | 5 | Current phase, 0 to 23 |
| addr_sel | output | 5 | One-hot address-bus source |
| addr_ld | output | 3 | Address-bus load strobes |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| dreg_sel | output | 8 | One-hot byte register driving the data bus |
| dreg_ld | output | 8 | One-hot byte register load |
| j_ld | output | 2 | J high (bit 1) and low (bit 0) byte loads |
| alu_oe | output | 1 | ALU result onto the data bus |
| alu_fn | output | 3 | ALU function code |
| cc_ld | output | 1 | Condition-code register load |
| imm_oe | output | 1 | Immediate value onto the data bus |
| imm_val | output | 8 | Sign-extended immediate |
| halted | output | 1 | Processor stopped |

## Verification
Every strobe is decoded without registers from the registered phase and opcode. All strobes for phase p are therefore valid for the whole cycle in which `phase` reads p. The bench samples them half a clock after the edge, against a model phase counter that advances on the same edge. The opcode presented on `mem_rdata` during phase 1 first shapes the strobes in phase 2, so the bench changes its model opcode only at that transition. Flags are held constant for a whole instruction, so the branch strobes of phases 20 to 23 follow the flags set at phase 0. The halt freeze is checked over several cycles at phase 4, and each freeze is followed by a reset whose first cycle is checked against R1.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;
  localparam int DW   = 8;
  localparam int NREG = 8;
  localparam int RW   = $clog2(NREG);

  localparam int AS_PC  = 0;
  localparam int AS_INC = 1;
  localparam int AS_M   = 2;
  localparam int AS_XY  = 3;
  localparam int AS_J   = 4;
  localparam int AS_N   = 5;

  localparam int AL_PC  = 0;
  localparam int AL_XY  = 1;
  localparam int AL_INC = 2;
  localparam int AL_N   = 3;

  typedef enum logic [3:0] {
    K_NOP, K_MOVE, K_ALU, K_LDI, K_LDM, K_STM, K_XYINC,
    K_MOV16, K_HALT, K_JMP, K_CALL, K_BR
  } kind_t;

  typedef struct packed {
    kind_t         kind;
    logic [RW-1:0] dst;
    logic [RW-1:0] src;
    logic [2:0]    fn;
    logic [DW-1:0] imm;
    logic [1:0]    cond;  // 0 sign, 1 carry, 2 zero, 3 not-zero
  } dec_t;

  function automatic logic kind_long(kind_t k);
    return (k == K_JMP) || (k == K_CALL) || (k == K_BR);
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_ctrl_pkg::*;
(
  input  logic [DW-1:0] ir,
  output dec_t          dec
);
  always_comb begin
    dec = '0;
    dec.kind = K_NOP;
    casez (ir)
      8'b00??????: begin
        dec.kind = K_MOVE;
        dec.dst  = ir[5:3];
        dec.src  = ir[2:0];
      end
      8'b01??????: begin
        dec.kind = K_LDI;
        dec.dst  = {2'b00, ir[5]};
        dec.imm  = {{(DW-5){ir[4]}}, ir[4:0]};
      end
      8'b1000????: begin
        dec.kind = K_ALU;
        dec.dst  = ir[3] ? 3'd3 : 3'd0;
        dec.fn   = ir[2:0];
      end
      8'b100100??: begin
        dec.kind = K_LDM;
        dec.dst  = {1'b0, ir[1:0]};
      end
      8'b100110??: begin
        dec.kind = K_STM;
        dec.src  = {1'b0, ir[1:0]};
      end
      8'b10101110: dec.kind = K_HALT;
      8'b1010???0: begin
        if (ir[2:1] != 2'b11) begin
          dec.kind = K_MOV16;
          dec.dst  = {2'b00, ir[3]};
          dec.src  = {1'b0, ir[2:1]};
        end
      end
      8'b10110000: dec.kind = K_XYINC;
      8'b11100110: dec.kind = K_JMP;
      8'b11100111: dec.kind = K_CALL;
      8'b11110000: begin dec.kind = K_BR; dec.cond = 2'd0; end
      8'b11101000: begin dec.kind = K_BR; dec.cond = 2'd1; end
      8'b11100100: begin dec.kind = K_BR; dec.cond = 2'd2; end
      8'b11100010: begin dec.kind = K_BR; dec.cond = 2'd3; end
      default:     dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/seq_phase.sv
module seq_phase #(
  parameter int BYTE_PH = 8,
  parameter int NBYTES  = 3,
  localparam int SW = $clog2(BYTE_PH),
  localparam int LW = $clog2(NBYTES),
  localparam int PW = $clog2(BYTE_PH * NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_long,
  input  logic          hold,
  output logic [SW-1:0] sub,
  output logic [LW-1:0] slot,
  output logic [PW-1:0] ph
);
  localparam logic [SW-1:0] SUB_LAST  = SW'(BYTE_PH - 1);
  localparam logic [LW-1:0] SLOT_LAST = LW'(NBYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub  <= '0;
      slot <= '0;
    end else if (!hold) begin
      if (sub == SUB_LAST) begin
        sub <= '0;
        if (!is_long || slot == SLOT_LAST) slot <= '0;
        else                                slot <= slot + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign ph = PW'(slot) * PW'(BYTE_PH) + PW'(sub);

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot <= SLOT_LAST) && (32'(sub) < BYTE_PH));
  assert_short_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0 && sub == SUB_LAST && !is_long && !hold) |=> (ph == '0));
  assert_hold_freeze_R14: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(ph));
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
  import seq_ctrl_pkg::*;
#(
  parameter int BYTE_PH = 8,
  parameter int NBYTES  = 3,
  localparam int SW = $clog2(BYTE_PH),
  localparam int LW = $clog2(NBYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dec_t            dec,
  input  logic [SW-1:0]   sub,
  input  logic [LW-1:0]   slot,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_s,
  output logic            ir_ld,
  output logic [AS_N-1:0] addr_sel,
  output logic [AL_N-1:0] addr_ld,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [NREG-1:0] dreg_sel,
  output logic [NREG-1:0] dreg_ld,
  output logic [1:0]      j_ld,
  output logic            alu_oe,
  output logic [2:0]      alu_fn,
  output logic            cc_ld,
  output logic            imm_oe,
  output logic [DW-1:0]   imm_val,
  output logic            halted
);
  localparam logic [LW-1:0] SLOT_LAST = LW'(NBYTES - 1);
  localparam logic [SW-1:0] EXEC0     = SW'(4);

  logic          is_long, in_fetch, in_exec, taken;
  logic [SW-1:0] e;
  logic [NREG-1:0] src_hot, dst_hot;

  assign is_long  = kind_long(dec.kind);
  assign in_fetch = (sub < EXEC0);
  assign in_exec  = !in_fetch && (slot == (is_long ? SLOT_LAST : '0));
  assign e        = sub - EXEC0;
  assign src_hot  = NREG'(1) << dec.src;
  assign dst_hot  = NREG'(1) << dec.dst;

  always_comb begin
    case (dec.cond)
      2'd0:    taken = flag_s;
      2'd1:    taken = flag_c;
      2'd2:    taken = flag_z;
      default: taken = !flag_z;
    endcase
  end

  always_comb begin
    ir_ld = 1'b0; addr_sel = '0; addr_ld = '0; mem_rd = 1'b0; mem_wr = 1'b0;
    dreg_sel = '0; dreg_ld = '0; j_ld = '0; alu_oe = 1'b0; alu_fn = '0;
    cc_ld = 1'b0; imm_oe = 1'b0; imm_val = '0; halted = 1'b0;
    if (in_fetch) begin
      case (sub)
        SW'(0): begin addr_sel[AS_PC] = 1'b1; mem_rd = 1'b1; end
        SW'(1): begin
          addr_sel[AS_PC] = 1'b1; mem_rd = 1'b1; addr_ld[AL_INC] = 1'b1;
          if (slot == '0)             ir_ld   = 1'b1;
          else if (slot == LW'(1))    j_ld[1] = 1'b1;
          else                        j_ld[0] = 1'b1;
        end
        SW'(2): addr_sel[AS_INC] = 1'b1;
        default: begin addr_sel[AS_INC] = 1'b1; addr_ld[AL_PC] = 1'b1; end
      endcase
    end else if (in_exec && e < SW'(4)) begin
      case (dec.kind)
        K_MOVE: if (e < SW'(2)) begin
          dreg_sel = src_hot;
          if (e == SW'(1)) dreg_ld = dst_hot;
        end
        K_ALU: if (e < SW'(2)) begin
          alu_oe = 1'b1; alu_fn = dec.fn;
          if (e == SW'(1)) begin dreg_ld = dst_hot; cc_ld = 1'b1; end
        end
        K_LDI: if (e < SW'(2)) begin
          imm_oe = 1'b1; imm_val = dec.imm;
          if (e == SW'(1)) dreg_ld = dst_hot;
        end
        K_LDM: if (e < SW'(2)) begin
          addr_sel[AS_M] = 1'b1; mem_rd = 1'b1;
          if (e == SW'(1)) dreg_ld = dst_hot;
        end
        K_STM: if (e < SW'(2)) begin
          addr_sel[AS_M] = 1'b1; dreg_sel = src_hot;
          if (e == SW'(1)) mem_wr = 1'b1;
        end
        K_XYINC: begin
          if (e == SW'(0)) begin addr_sel[AS_XY] = 1'b1; addr_ld[AL_INC] = 1'b1; end
          else if (e == SW'(1)) addr_sel[AS_INC] = 1'b1;
          else if (e == SW'(2)) begin addr_sel[AS_INC] = 1'b1; addr_ld[AL_XY] = 1'b1; end
        end
        K_MOV16: if (e < SW'(2)) begin
          case (dec.src[1:0])
            2'd0:    addr_sel[AS_M]  = 1'b1;
            2'd1:    addr_sel[AS_XY] = 1'b1;
            default: addr_sel[AS_J]  = 1'b1;
          endcase
          if (e == SW'(1)) begin
            if (dec.dst[0]) addr_ld[AL_PC] = 1'b1;
            else            addr_ld[AL_XY] = 1'b1;
          end
        end
        K_HALT: if (e == SW'(0)) halted = 1'b1;
        K_JMP, K_BR: if ((dec.kind == K_JMP || taken) && e < SW'(2)) begin
          addr_sel[AS_J] = 1'b1;
          if (e == SW'(1)) addr_ld[AL_PC] = 1'b1;
        end
        K_CALL: begin
          if (e < SW'(2)) begin
            addr_sel[AS_PC] = 1'b1;
            if (e == SW'(1)) addr_ld[AL_XY] = 1'b1;
          end else begin
            addr_sel[AS_J] = 1'b1;
            if (e == SW'(3)) addr_ld[AL_PC] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_addr_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(addr_sel));
  assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_dreg_ld_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dreg_ld));
  assert_cc_with_alu_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cc_ld |-> alu_oe);
  assert_jld_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|j_ld) |-> (mem_rd && addr_sel[AS_PC]));
  assert_pc_not_self_R11: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld[AL_PC] |-> !addr_sel[AS_PC]);
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_ctrl_pkg::*;
#(
  parameter int BYTE_PH = 8,
  parameter int NBYTES  = 3,
  localparam int PW = $clog2(BYTE_PH * NBYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      mem_rdata,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_s,
  output logic [PW-1:0]   phase,
  output logic [4:0]      addr_sel,
  output logic [2:0]      addr_ld,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [7:0]      dreg_sel,
  output logic [7:0]      dreg_ld,
  output logic [1:0]      j_ld,
  output logic            alu_oe,
  output logic [2:0]      alu_fn,
  output logic            cc_ld,
  output logic            imm_oe,
  output logic [7:0]      imm_val,
  output logic            halted
);
  localparam int SW = $clog2(BYTE_PH);
  localparam int LW = $clog2(NBYTES);

  logic [DW-1:0] ir;
  logic          ir_ld;
  dec_t          dec;
  logic [SW-1:0] sub;
  logic [LW-1:0] slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir <= '0;
    else if (ir_ld) ir <= mem_rdata;
  end

  seq_decode u_dec (.ir(ir), .dec(dec));

  seq_phase #(.BYTE_PH(BYTE_PH), .NBYTES(NBYTES)) u_phase (
    .clk(clk), .rst_n(rst_n), .is_long(kind_long(dec.kind)), .hold(halted),
    .sub(sub), .slot(slot), .ph(phase)
  );

  seq_strobes #(.BYTE_PH(BYTE_PH), .NBYTES(NBYTES)) u_strb (
    .clk(clk), .rst_n(rst_n), .dec(dec), .sub(sub), .slot(slot),
    .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s),
    .ir_ld(ir_ld), .addr_sel(addr_sel), .addr_ld(addr_ld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .dreg_sel(dreg_sel), .dreg_ld(dreg_ld),
    .j_ld(j_ld), .alu_oe(alu_oe), .alu_fn(alu_fn), .cc_ld(cc_ld),
    .imm_oe(imm_oe), .imm_val(imm_val), .halted(halted)
  );

  assert_halt_sticky_R14: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && addr_sel == '0 && !mem_rd && !mem_wr));
  assert_ir_only_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase > PW'(1)) |=> $stable(ir) || phase == '0 || phase == PW'(1) || $past(phase) == PW'(1));
endmodule

// File: tb/instr_sequencer_bench.sv
`timescale 1ns/1ps
module instr_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic flag_z = 1'b0, flag_c = 1'b0, flag_s = 1'b0;
  logic [4:0] phase, addr_sel;
  logic [2:0] addr_ld, alu_fn;
  logic mem_rd, mem_wr, alu_oe, cc_ld, imm_oe, halted;
  logic [7:0] dreg_sel, dreg_ld, imm_val;
  logic [1:0] j_ld;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  instr_sequencer u_instr_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
    .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s),
    .phase(phase), .addr_sel(addr_sel), .addr_ld(addr_ld),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .dreg_sel(dreg_sel), .dreg_ld(dreg_ld),
    .j_ld(j_ld), .alu_oe(alu_oe), .alu_fn(alu_fn), .cc_ld(cc_ld),
    .imm_oe(imm_oe), .imm_val(imm_val), .halted(halted)
  );

  // kinds: 0 nop 1 move 2 alu 3 ldi 4 ldm 5 stm 6 xyinc 7 wide 8 halt 9 jmp 10 call 11 br
  function automatic int kind_of(input logic [7:0] op);
    if (op[7:6] == 2'b00) return 1;
    if (op[7:6] == 2'b01) return 3;
    if (op[7:4] == 4'b1000) return 2;
    if (op[7:2] == 6'b100100) return 4;
    if (op[7:2] == 6'b100110) return 5;
    if (op == 8'hAE) return 8;
    if (op[7:4] == 4'b1010 && op[0] == 1'b0 && op[2:1] != 2'b11) return 7;
    if (op == 8'hB0) return 6;
    if (op == 8'hE6) return 9;
    if (op == 8'hE7) return 10;
    if (op == 8'hF0 || op == 8'hE8 || op == 8'hE4 || op == 8'hE2) return 11;
    return 0;
  endfunction

  function automatic bit br_taken(input logic [7:0] op, input logic z, c, s);
    case (op)
      8'hF0: return s;
      8'hE8: return c;
      8'hE4: return z;
      default: return !z;
    endcase
  endfunction

  function automatic logic [47:0] exp_vec(input logic [7:0] op, input int ph,
                                          input logic z, c, s);
    logic [4:0] as_; logic [2:0] al; logic rd, wr; logic [7:0] ds, dl, iv;
    logic [1:0] jl; logic ao, cc, io, hl; logic [2:0] fn;
    int k, slot, sub, e; bit lng;
    as_ = '0; al = '0; rd = 0; wr = 0; ds = '0; dl = '0; iv = '0; jl = '0;
    ao = 0; cc = 0; io = 0; hl = 0; fn = '0;
    k = kind_of(op); lng = (k >= 9); slot = ph / 8; sub = ph % 8; e = sub - 4;
    if (sub < 4) begin
      if (sub <= 1) begin as_ = 5'b00001; rd = 1; end
      if (sub == 1) begin
        al = 3'b100;
        if (slot == 1) jl = 2'b10;
        if (slot == 2) jl = 2'b01;
      end
      if (sub >= 2) as_ = 5'b00010;
      if (sub == 3) al = 3'b001;
    end else if (slot == (lng ? 2 : 0)) begin
      case (k)
        1: if (e < 2) begin ds = 8'(1) << op[2:0]; if (e == 1) dl = 8'(1) << op[5:3]; end
        2: if (e < 2) begin ao = 1; fn = op[2:0];
             if (e == 1) begin dl = op[3] ? 8'h08 : 8'h01; cc = 1; end end
        3: if (e < 2) begin io = 1; iv = {{3{op[4]}}, op[4:0]};
             if (e == 1) dl = op[5] ? 8'h02 : 8'h01; end
        4: if (e < 2) begin as_ = 5'b00100; rd = 1; if (e == 1) dl = 8'(1) << op[1:0]; end
        5: if (e < 2) begin as_ = 5'b00100; ds = 8'(1) << op[1:0]; if (e == 1) wr = 1; end
        6: begin
             if (e == 0) begin as_ = 5'b01000; al = 3'b100; end
             if (e == 1) as_ = 5'b00010;
             if (e == 2) begin as_ = 5'b00010; al = 3'b010; end
           end
        7: if (e < 2) begin
             as_ = (op[2:1] == 2'b00) ? 5'b00100 : (op[2:1] == 2'b01) ? 5'b01000 : 5'b10000;
             if (e == 1) al = op[3] ? 3'b001 : 3'b010;
           end
        8: if (e == 0) hl = 1;
        9, 11: if ((k == 9 || br_taken(op, z, c, s)) && e < 2) begin
             as_ = 5'b10000; if (e == 1) al = 3'b001; end
        10: begin
             as_ = (e < 2) ? 5'b00001 : 5'b10000;
             if (e == 1) al = 3'b010;
             if (e == 3) al = 3'b001;
           end
        default: ;
      endcase
    end
    return {5'(ph), as_, al, rd, wr, ds, dl, jl, ao, fn, cc, io, iv, hl};
  endfunction

  function automatic string req_tag(input logic [7:0] op, input int ph, input bit rst_flag,
                                    input logic z, c, s);
    int k; k = kind_of(op);
    if (rst_flag) return "R1";
    if (ph < 4) return "R2";
    if (k >= 9 && ph < 20) return (ph % 8 < 4) ? "R10" : "R3";
    case (k)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      7: return "R9";
      8: return "R14";
      9: return "R11";
      10: return "R13";
      11: return br_taken(op, z, c, s) ? "R11" : "R12";
      default: return "R3";
    endcase
  endfunction

  task automatic check_now(input logic [7:0] op, input int ph, input bit rst_flag);
    logic [47:0] act, exp;
    string tag;
    act = {phase, addr_sel, addr_ld, mem_rd, mem_wr, dreg_sel, dreg_ld, j_ld,
           alu_oe, alu_fn, cc_ld, imm_oe, imm_val, halted};
    exp = exp_vec(op, ph, flag_z, flag_c, flag_s);
    tag = req_tag(op, ph, rst_flag, flag_z, flag_c, flag_s);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%h phase=%0d actual=%h expected=%h", tag, op, ph, act, exp);
    end
  endtask

  // directed: {z,c,s, opcode}
  localparam int ND = 24;
  function automatic logic [10:0] directed(input int i);
    case (i)
      0:  return {3'b000, 8'h39}; 1:  return {3'b000, 8'h50};
      2:  return {3'b000, 8'h6F}; 3:  return {3'b000, 8'h87};
      4:  return {3'b000, 8'h8D}; 5:  return {3'b000, 8'h93};
      6:  return {3'b000, 8'h9A}; 7:  return {3'b000, 8'hB0};
      8:  return {3'b000, 8'hAA}; 9:  return {3'b000, 8'hA4};
      10: return {3'b000, 8'hA6}; 11: return {3'b000, 8'hE6};
      12: return {3'b000, 8'hE7}; 13: return {3'b001, 8'hF0};
      14: return {3'b110, 8'hF0}; 15: return {3'b010, 8'hE8};
      16: return {3'b101, 8'hE8}; 17: return {3'b100, 8'hE4};
      18: return {3'b011, 8'hE4}; 19: return {3'b000, 8'hE2};
      20: return {3'b111, 8'hE2}; 21: return {3'b000, 8'hC0};
      22: return {3'b000, 8'hFF}; default: return {3'b000, 8'hAE};
    endcase
  endfunction

  function automatic logic [7:0] rand_op();
    int r; r = int'($urandom % 16);
    case (r)
      0, 1, 2: return {2'b00, 6'($urandom)};
      3, 4:    return {4'b1000, 4'($urandom)};
      5, 6:    return {2'b01, 6'($urandom)};
      7:       return {6'b100100, 2'($urandom)};
      8:       return {6'b100110, 2'($urandom)};
      9:       return 8'hB0;
      10:      return {4'b1010, 3'($urandom), 1'b0};
      11:      return 8'hE6;
      12:      return 8'hE7;
      13:      return 8'hF0 >> ($urandom % 2) | 8'h00;
      14:      begin
                 case ($urandom % 4)
                   0: return 8'hF0; 1: return 8'hE8; 2: return 8'hE4; default: return 8'hE2;
                 endcase
               end
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    automatic int bph = 0;
    automatic logic [7:0] bir = 8'h00, nop = 8'h00, hi = 8'h00, lo = 8'h00;
    automatic bit rst_flag = 1;
    automatic int n_instr = 0, halt_cnt = 0;
    void'($urandom(32'h5EED_1234));
    // reset state while held
    @(negedge clk);
    check_now(8'h00, 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    while (n_instr < 420) begin
      if (bph == 0 && halt_cnt == 0) begin
        logic [10:0] d;
        if (n_instr < ND) d = directed(n_instr);
        else if (n_instr % 60 == 59) d = {3'($urandom), 8'hAE};
        else d = {3'($urandom), rand_op()};
        nop = d[7:0];
        {flag_z, flag_c, flag_s} = d[10:8];
        hi = 8'($urandom); lo = 8'($urandom);
        n_instr++;
      end
      case (bph)
        0, 1:   mem_rdata = nop;
        8, 9:   mem_rdata = hi;
        16, 17: mem_rdata = lo;
        default: mem_rdata = 8'($urandom);
      endcase
      #1;
      check_now((bph <= 1) ? nop : bir, bph, rst_flag);
      rst_flag = 0;
      @(posedge clk);
      if (bph == 1) bir = nop;
      if (kind_of(bir) == 8 && bph == 4) begin
        halt_cnt++;
      end else if ((bph == 7 && kind_of(bir) < 9) || bph == 23) bph = 0;
      else bph++;
      @(negedge clk);
      if (halt_cnt >= 6) begin
        rst_n = 1'b0;
        #1;
        check_now(8'h00, 0, 1);
        @(negedge clk);
        rst_n = 1'b1;
        bph = 0; halt_cnt = 0; rst_flag = 1; bir = 8'h00;
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule